// File: doc/BRIEF.md
# Multi-Channel PWM Controller with Shadowed Updates

The block drives several independent pulse-width outputs, each configured through a small word-addressed register bus. Every channel owns a mode word, an inactive-time word, a period word and an update word. A per-channel counter steps at the input clock divided by a power of two and wraps at the period length. The output starts each period at a level chosen by a polarity bit. It flips once the count reaches the stored inactive time, so the active portion lasts for the period value minus the inactive-time value.

Software configures a channel while it is stopped by writing the inactive-time and period words directly. Once the channel runs, those words are frozen. New values are queued through the update word, and a mode bit steers each write to either the inactive-time shadow or the period shadow. Queued values move into the live registers only at the wrap of the period. A completion flag per channel then sets, and it clears when software reads it. Two global words start and stop channels by bit mask, and a third reports which channels are running.

Word map: global words 0 (start mask), 1 (stop mask), 2 (running mask), 3 (completion flags). Channel n occupies words 4+4n (mode), 5+4n (inactive time), 6+4n (period) and 7+4n (update). Mode word fields: bits 3:0 prescale code, bit 8 polarity, bit 10 update target.

Top module: `pwm_multi`

## Requirements
- R1: After reset all channels are stopped, every output is low, and the running mask, the completion flags and all channel words read zero.
- R2: Writing word 0 starts each stopped channel whose bit is one, with its counter at 0. Running channels and zero bits are unaffected. Writing word 1 stops each channel whose bit is one. Word 2 reads the running mask.
- R3: A running channel's counter advances once every 2^N clocks, where N is mode bits 3:0. A mode write whose code exceeds PRE_MAX leaves the stored code unchanged.
- R4: The counter counts from 0 up to period-1 and then returns to 0. A period of 0 or 1 holds the counter at 0.
- R5: Output n equals polarity XOR (running AND count >= inactive time). With polarity 0 the output is low while stopped and high for (period - inactive time) counts of each period.
- R6: While a channel is stopped, writes to its mode, inactive-time and period words take effect at once. While it runs, writes to the inactive-time and period words are ignored, and a mode write changes only bit 10, so polarity and prescale stay fixed.
- R7: A write to the update word of a running channel loads the inactive-time shadow when mode bit 10 is 0 and the period shadow when it is 1. The shadow is copied into the live register at the next wrap, and only the last value written before that wrap is applied. Update writes to a stopped channel are ignored.
- R8: At a wrap that applies a queued value, bit n of word 3 sets. A read of word 3 returns the flags and then clears them, but a flag set in the same cycle as the read survives.
- R9: Stopping a channel discards its queued values. The live inactive-time and period words keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| rd_en_i | input | 1 | Read strobe; triggers clear-on-read of the flag word |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the addressed word (combinational) |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
The bench builds the block with two channels, an 8-bit counter and PRE_MAX of 2. With this build, prescale code 3 is a reachable invalid code, and periods of a few counts produce many wraps within a short run. Directed phases cover direct configuration, the frozen words during a run, steering of the update word, last-write-wins, clear-on-read and discarding on stop. These phases are followed by a long pseudo-random mix of writes, reads, starts and stops. In every cycle a behavioural model compares both outputs and the read data. Update values landing exactly on a wrap cycle and reads racing a flag set are reached by that random mix.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_FLD_W = 4;
  localparam int POL_BIT   = 8;
  localparam int TGT_BIT   = 10;
  localparam int A_ENA     = 0;
  localparam int A_DIS     = 1;
  localparam int A_STAT    = 2;
  localparam int A_IRQ     = 3;
  localparam int CH_BASE   = 1;   // first channel group of four words

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_DUTY = 2'd1,
    REG_PRD  = 2'd2,
    REG_UPD  = 2'd3
  } ch_reg_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_MAX = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);
  localparam int DIV_W = (PRE_MAX > 0) ? PRE_MAX : 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  for (genvar k = 0; k < DIV_W; k++) begin : g_mask
    assign mask[k] = (int'(code_i) > k);
  end

  assign tick_o = run_i && (div_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || tick_o)  div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_glob.sv
module pwm_glob #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ena_wr_i,
  input  logic              dis_wr_i,
  input  logic              irq_rd_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] stop_o
);
  logic [NUM_CH-1:0] en_q, irq_q;

  assign start_o = ena_wr_i ? (mask_i & ~en_q) : '0;
  assign stop_o  = dis_wr_i ? mask_i : '0;
  assign en_o    = en_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      irq_q <= '0;
    end else begin
      en_q  <= (en_q | start_o) & ~stop_o;
      irq_q <= (irq_rd_i ? '0 : irq_q) | done_i;  // new set beats clear
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_MAX = 10,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_i,
  input  ch_reg_e           sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pwm_o,
  output logic              done_o,
  output logic              pol_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic [CNT_W-1:0]  prd_o
);
  logic [PRE_FLD_W-1:0] pre_q;
  logic                 pol_q, tgt_q;
  logic [CNT_W-1:0]     duty_q, prd_q, shd_q, shp_q, cnt_q;
  logic                 pend_d_q, pend_p_q;
  logic                 tick, wrap, pre_ok;
  logic [CNT_W:0]       cnt_inc;
  logic [CNT_W-1:0]     wval;
  logic [PRE_FLD_W-1:0] pre_new;
  logic                 unused_wd;

  assign unused_wd = ^wdata_i;
  assign wval      = wdata_i[CNT_W-1:0];
  assign pre_new   = wdata_i[PRE_FLD_W-1:0];
  assign pre_ok    = (int'(pre_new) <= PRE_MAX);

  pwm_prescaler #(.PRE_MAX(PRE_MAX)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (en_i),
    .code_i(pre_q),
    .tick_o(tick)
  );

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap    = tick && (cnt_inc >= {1'b0, prd_q});
  assign done_o  = wrap && (pend_d_q || pend_p_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q    <= '0;
      pol_q    <= 1'b0;
      tgt_q    <= 1'b0;
      duty_q   <= '0;
      prd_q    <= '0;
      shd_q    <= '0;
      shp_q    <= '0;
      cnt_q    <= '0;
      pend_d_q <= 1'b0;
      pend_p_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= wrap ? '0 : cnt_inc[CNT_W-1:0];
      if (wrap) begin
        if (pend_d_q) duty_q <= shd_q;
        if (pend_p_q) prd_q  <= shp_q;
        pend_d_q <= 1'b0;
        pend_p_q <= 1'b0;
      end
      if (wr_i) begin
        unique case (sel_i)
          REG_MODE: begin
            if (!en_i) begin
              if (pre_ok) pre_q <= pre_new;
              pol_q <= wdata_i[POL_BIT];
            end
            tgt_q <= wdata_i[TGT_BIT];
          end
          REG_DUTY: if (!en_i) duty_q <= wval;
          REG_PRD:  if (!en_i) prd_q  <= wval;
          REG_UPD: begin
            if (en_i) begin
              if (tgt_q) begin
                shp_q    <= wval;
                pend_p_q <= 1'b1;
              end else begin
                shd_q    <= wval;
                pend_d_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      if (start_i || stop_i) cnt_q <= '0;
      if (stop_i) begin
        pend_d_q <= 1'b0;
        pend_p_q <= 1'b0;
      end
    end
  end

  assign pwm_o  = pol_q ^ (en_i && (cnt_q >= duty_q));
  assign pol_o  = pol_q;
  assign duty_o = duty_q;
  assign prd_o  = prd_q;

  always_comb begin
    mode_o                  = '0;
    mode_o[PRE_FLD_W-1:0]   = pre_q;
    mode_o[POL_BIT]         = pol_q;
    mode_o[TGT_BIT]         = tgt_q;
  end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int PRE_MAX = 10,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int GRP_W = ADDR_W - 2;

  logic [GRP_W-1:0]  grp;
  ch_reg_e           sel;
  logic              glob_hit, ena_wr, dis_wr, irq_rd;
  logic [NUM_CH-1:0] en_q, irq_q, start_w, stop_w, done_w, pol_w;
  logic [DATA_W-1:0] mode_w [NUM_CH];
  logic [CNT_W-1:0]  duty_w [NUM_CH];
  logic [CNT_W-1:0]  prd_w  [NUM_CH];

  assign grp      = addr_i[ADDR_W-1:2];
  assign sel      = ch_reg_e'(addr_i[1:0]);
  assign glob_hit = (grp == '0);
  assign ena_wr   = wr_en_i && glob_hit && (addr_i[1:0] == 2'(A_ENA));
  assign dis_wr   = wr_en_i && glob_hit && (addr_i[1:0] == 2'(A_DIS));
  assign irq_rd   = rd_en_i && glob_hit && (addr_i[1:0] == 2'(A_IRQ));

  pwm_glob #(.NUM_CH(NUM_CH)) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ena_wr_i(ena_wr),
    .dis_wr_i(dis_wr),
    .irq_rd_i(irq_rd),
    .mask_i  (wdata_i[NUM_CH-1:0]),
    .done_i  (done_w),
    .en_o    (en_q),
    .irq_o   (irq_q),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en_i && (grp == GRP_W'(g + CH_BASE));

    pwm_channel #(
      .CNT_W  (CNT_W),
      .PRE_MAX(PRE_MAX),
      .DATA_W (DATA_W)
    ) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_q[g]),
      .start_i(start_w[g]),
      .stop_i (stop_w[g]),
      .wr_i   (ch_wr),
      .sel_i  (sel),
      .wdata_i(wdata_i),
      .pwm_o  (pwm_o[g]),
      .done_o (done_w[g]),
      .pol_o  (pol_w[g]),
      .mode_o (mode_w[g]),
      .duty_o (duty_w[g]),
      .prd_o  (prd_w[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (glob_hit) begin
      if (addr_i[1:0] == 2'(A_STAT)) rdata_o[NUM_CH-1:0] = en_q;
      if (addr_i[1:0] == 2'(A_IRQ))  rdata_o[NUM_CH-1:0] = irq_q;
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (grp == GRP_W'(n + CH_BASE)) begin
        unique case (sel)
          REG_MODE: rdata_o            = mode_w[n];
          REG_DUTY: rdata_o[CNT_W-1:0] = duty_w[n];
          REG_PRD:  rdata_o[CNT_W-1:0] = prd_w[n];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] irq_q,
  input logic [NUM_CH-1:0] pol_w
);
  localparam logic [ADDR_W-1:0] AD_ENA  = ADDR_W'(A_ENA);
  localparam logic [ADDR_W-1:0] AD_DIS  = ADDR_W'(A_DIS);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_IRQ  = ADDR_W'(A_IRQ);

  logic [NUM_CH-1:0] wm;
  logic              unused_chk;
  assign wm         = wdata_i[NUM_CH-1:0];
  assign unused_chk = ^wdata_i;

  AST_ENA_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AD_ENA) |=> ((en_q & $past(wm)) == $past(wm)));  // R2
  AST_DIS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AD_DIS) |=> ((en_q & $past(wm)) == '0));  // R2
  AST_STAT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AD_STAT) |-> (rdata_o[NUM_CH-1:0] == en_q));  // R2
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == AD_IRQ) |=> ((irq_q & $past(irq_q)) == $past(irq_q)));  // R8
  AST_POL_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((en_q & $past(en_q) & (pol_w ^ $past(pol_w))) == '0));  // R6
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~en_q) & (pwm_o ^ pol_w)) == '0);  // R5
endmodule

bind pwm_multi pwm_multi_chk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .pwm_o  (pwm_o),
  .en_q   (en_q),
  .irq_q  (irq_q),
  .pol_w  (pol_w)
);

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb;
  localparam int NCH = 2;
  localparam int CW  = 8;
  localparam int PM  = 2;
  localparam int AW  = 6;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] pwm;

  int n_cmp = 0, n_bad = 0;
  bit fin = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  pwm_multi #(.NUM_CH(NCH), .CNT_W(CW), .PRE_MAX(PM), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // behavioural reference
  int m_en[NCH], m_pre[NCH], m_pc[NCH], m_cnt[NCH], m_pol[NCH], m_tgt[NCH];
  int m_duty[NCH], m_prd[NCH], m_shd[NCH], m_shp[NCH], m_pd[NCH], m_pp[NCH], m_irq[NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_pre[c] = 0; m_pc[c] = 0; m_cnt[c] = 0; m_pol[c] = 0; m_tgt[c] = 0;
        m_duty[c] = 0; m_prd[c] = 0; m_shd[c] = 0; m_shp[c] = 0; m_pd[c] = 0; m_pp[c] = 0;
        m_irq[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int old_en, base, wv, setf;
        bit tick;
        old_en = m_en[c];
        base = 4 + 4 * c;
        wv = int'(wdata) & ((1 << CW) - 1);
        setf = 0;
        tick = (old_en != 0) && (m_pc[c] == (1 << m_pre[c]) - 1);
        if (old_en != 0) m_pc[c] = tick ? 0 : m_pc[c] + 1;
        if (tick) begin
          if (m_cnt[c] + 1 >= m_prd[c]) begin
            m_cnt[c] = 0;
            if (m_pd[c] != 0 || m_pp[c] != 0) setf = 1;
            if (m_pd[c] != 0) m_duty[c] = m_shd[c];
            if (m_pp[c] != 0) m_prd[c] = m_shp[c];
            m_pd[c] = 0; m_pp[c] = 0;
          end else m_cnt[c] = m_cnt[c] + 1;
        end
        if (wr_en) begin
          if (int'(addr) == base) begin
            if (old_en == 0) begin
              if (int'(wdata[3:0]) <= PM) m_pre[c] = int'(wdata[3:0]);
              m_pol[c] = int'(wdata[8]);
            end
            m_tgt[c] = int'(wdata[10]);
          end
          if (int'(addr) == base + 1 && old_en == 0) m_duty[c] = wv;
          if (int'(addr) == base + 2 && old_en == 0) m_prd[c] = wv;
          if (int'(addr) == base + 3 && old_en != 0) begin
            if (m_tgt[c] != 0) begin m_shp[c] = wv; m_pp[c] = 1; end
            else begin m_shd[c] = wv; m_pd[c] = 1; end
          end
          if (addr == 0 && wdata[c] && old_en == 0) begin
            m_en[c] = 1; m_cnt[c] = 0; m_pc[c] = 0;
          end
          if (addr == 1 && wdata[c]) begin
            m_en[c] = 0; m_cnt[c] = 0; m_pc[c] = 0; m_pd[c] = 0; m_pp[c] = 0;
          end
        end
        if (rd_en && addr == 3) m_irq[c] = 0;
        if (setf != 0) m_irq[c] = 1;
      end
    end
  end

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    int g, r, c;
    logic [DW-1:0] v;
    v = '0;
    g = int'(a) / 4;
    r = int'(a) % 4;
    if (g == 0) begin
      for (int k = 0; k < NCH; k++) begin
        if (r == 2) v[k] = (m_en[k] != 0);
        if (r == 3) v[k] = (m_irq[k] != 0);
      end
    end else if (g - 1 < NCH) begin
      c = g - 1;
      case (r)
        0: v = DW'(m_pre[c] | (m_pol[c] << 8) | (m_tgt[c] << 10));
        1: v = DW'(m_duty[c]);
        2: v = DW'(m_prd[c]);
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    if (a == 2) return "R2";
    if (a == 3) return "R8";
    if (a >= 4 && a[1:0] == 2'd3) return "R7";
    if (a >= 4) return "R6";
    return phase;
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    #2;
    if (rst_n && !fin) begin
      for (int c = 0; c < NCH; c++) begin
        logic e;
        e = 1'(m_pol[c]) ^ ((m_en[c] != 0) && (m_cnt[c] >= m_duty[c]));
        n_cmp++;
        if (pwm[c] !== e) begin
          n_bad++;
          $display("FAIL R5 (%s) pwm ch%0d got %0b exp %0b t=%0t", phase, c, pwm[c], e, $time);
        end
      end
      n_cmp++;
      if (rdata !== exp_rd(addr)) begin
        n_bad++;
        $display("FAIL %s (%s) rdata @%0d got %h exp %h t=%0t", rd_tag(addr), phase, addr, rdata,
                 exp_rd(addr), $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    #2 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (%s)", phase);
    summary();
  end

  initial begin
    logic [DW-1:0] v;
    logic [31:0] s;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    phase = "R1";
    #2 chk("R1 pwm", DW'(pwm), '0);
    rd(2, v); chk("R1 stat", v, '0);
    rd(3, v); chk("R1 irq", v, '0);
    rd(4, v); chk("R1 mode0", v, '0);
    rd(6, v); chk("R1 prd0", v, '0);

    // R6 direct writes while stopped, R3 invalid code
    phase = "R6";
    wr(4, 32'h001); wr(5, 2); wr(6, 5);
    rd(4, v); chk("R6 mode0", v, 32'h001);
    rd(5, v); chk("R6 duty0", v, 2);
    rd(6, v); chk("R6 prd0", v, 5);
    phase = "R3";
    wr(8, 32'h003);
    rd(8, v); chk("R3 invalid code held", v, 32'h000);
    // R7 update ignored while stopped
    wr(7, 9);
    rd(5, v); chk("R7 stopped update ignored", v, 2);

    // R2 start; R3/R5 active time: pre 1, prd 5, duty 2 -> 12 high of 20 clocks
    phase = "R2";
    wr(0, 1);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      #2 if (pwm[0]) hi++;
      @(negedge clk);
    end
    chk("R3 R5 high clocks", DW'(hi), 12);
    rd(2, v); chk("R2 stat", v, 1);

    // R6 frozen while running
    phase = "R6";
    wr(5, 4); wr(6, 9); wr(4, 32'h500);
    rd(5, v); chk("R6 duty frozen", v, 2);
    rd(6, v); chk("R6 prd frozen", v, 5);
    rd(4, v); chk("R6 only target changes", v, 32'h401);

    // R7 period update, last write wins; R8 flag and clear
    phase = "R7";
    rd(3, v);
    wr(7, 7); wr(7, 8);
    idle(30);
    rd(6, v); chk("R7 period last wins", v, 8);
    rd(5, v); chk("R7 duty untouched", v, 2);
    phase = "R8";
    rd(3, v); chk("R8 flag set", v, 1);
    rd(3, v); chk("R8 cleared on read", v, 0);

    // R7 duty update
    phase = "R7";
    wr(4, 32'h000);
    wr(7, 1);
    idle(40);
    rd(5, v); chk("R7 duty applied", v, 1);
    rd(3, v);

    // R9 stop discards queue
    phase = "R9";
    wr(7, 3); wr(1, 1);
    rd(5, v); chk("R9 duty kept", v, 1);
    wr(0, 1);
    idle(40);
    rd(5, v); chk("R9 discarded after restart", v, 1);
    rd(3, v); chk("R9 no flag", v, 0);

    // R4 period 1 holds count 0; polarity 1, duty 0 -> output low while running
    phase = "R4";
    wr(8, 32'h100); wr(9, 0); wr(10, 1);
    #2 chk("R4 idle level pol1", DW'(pwm[1]), 1);
    wr(0, 2);
    idle(5);
    #2 chk("R4 prd1 output", DW'(pwm[1]), 0);
    wr(1, 2); wr(10, 0); wr(0, 2);
    idle(5);
    #2 chk("R4 prd0 output", DW'(pwm[1]), 0);

    // mixed traffic
    phase = "R7 random";
    s = 32'h1234_5678;
    for (int i = 0; i < 6000; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      if (s[31:30] != 2'b00) begin
        int a;
        a = int'(s[29:24]) % 12;
        if ((a == 1 || a == 0) && s[23:21] != 3'b000) a = 4 + int'(s[20]) * 4 + 3;
        addr = AW'(a);
        wdata = s & 32'h0000_050F;
        if (s[19]) begin wr_en = 1'b1; end
        else rd_en = 1'b1;
      end else begin
        addr = AW'(int'(s[29:28]) + 2);
      end
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(4);
    summary();
  end
endmodule